// File: doc/BRIEF.md
# Threaded-Code Inner Interpreter Core

This block is a small processor core with 16-bit cells and word addressing. It runs the few machine instructions that a threaded Forth system needs to step from one word to the next. It keeps two separate program counters. The machine counter (`pc`) selects the next machine instruction. The thread pointer (`ip`) selects the next cell of the Forth thread. The core also holds the address of the word that is currently executing (`a`) and a pointer (`sp`) to the data stack. The data stack grows upward through memory.

The core supports exactly four instructions. One pushes the cell that `ip` addresses onto the data stack. One advances `ip`. One loads `a` from the cell that `ip` addresses. One jumps to the cell after the one that `a` names. Running the last three in that order makes up the interpreter's "next" step. Any other instruction word raises a sticky fault flag and halts the core until reset. The core talks to one single-port memory with a one-cycle read latency. The architectural registers are brought out as ports, together with a one-cycle pulse that marks each retired instruction, so that an environment can follow execution step by step.

Top module: `fth_core`

## Requirements
- R1: While reset is held, and in the cycle after it is released, the core shows pc=0x0008, ip=0x0033, a=0x0032, sp=0x0039. Retire, fault and memory write are all low.
- R2: Word 0x9613 reads the cell at `ip` and writes it to address `sp`. It then increments `sp` by one. The instruction takes 4 cycles.
- R3: Word 0x7003 increments `ip` by one. The instruction takes 3 cycles.
- R4: Word 0x2043 loads `a` with the cell at `ip`. The instruction takes 4 cycles.
- R5: Word 0x2004 sets `pc` to `a`+1 (modulo 2^16). It performs no memory read of data and no write. The instruction takes 3 cycles.
- R6: Every supported instruction other than 0x2004 increments `pc` by one.
- R7: `retire_o` is high for exactly one cycle after each instruction. That cycle is the first one in which the new register values appear. The registers never change in any other cycle.
- R8: Any other instruction word sets `illegal_o` in the cycle after decode. From then until reset, no register changes, no memory write occurs and no instruction retires.
- R9: Memory reads return data one cycle after the address is presented. A write happens only in the last cycle of a 0x9613, at address `sp`, and it is followed by a retire.
- R10: Starting from the reset state with a thread of literal, 0x0003 and a word whose address is 0x002E, the sequence push / advance / load / advance / jump ends with ip=0x0035, sp=0x003A, a=0x002E and pc=0x002F. Cell 0x0039 then holds 0x0003, and cell 0x003A is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr_o | output | 16 | Memory address for reads and writes |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Read data for the address presented in the previous cycle |
| pc_o | output | 16 | Machine program counter |
| ip_o | output | 16 | Thread pointer |
| a_o | output | 16 | Address of the active word |
| sp_o | output | 16 | Data stack pointer (next free cell) |
| retire_o | output | 1 | One-cycle pulse when an instruction's results appear |
| illegal_o | output | 1 | Sticky unsupported-instruction flag; the core is halted |

## Verification
The bench targets these corner cases:
- **Jump through an `a` of 0xFFFF.** The new `pc` must wrap to 0x0000. A design that adds with the wrong width, or that jumps to `a` itself, fetches from the wrong cell.
- **Three pushes in a row.** These expose a stack pointer that fails to advance, or a write that lands one cell off.
- **Write data taken from the wrong cycle.** A core that samples read data in the wrong cycle pushes the instruction word instead of the thread cell.
- **Near-miss opcodes and instruction words of zero.** These must halt the core at once. A core that treats them as a known instruction, or that keeps fetching, changes registers or writes memory after the fault.
- **Reset after a fault.** This must clear the fault.

// File: rtl/fth_pkg.sv
package fth_pkg;
  localparam int OPC_W = 16;

  localparam logic [OPC_W-1:0] OPC_PUSH  = 16'h9613;
  localparam logic [OPC_W-1:0] OPC_INCIP = 16'h7003;
  localparam logic [OPC_W-1:0] OPC_LDA   = 16'h2043;
  localparam logic [OPC_W-1:0] OPC_JMPA  = 16'h2004;

  typedef enum logic [2:0] {
    ST_FETCH = 3'd0,
    ST_DEC   = 3'd1,
    ST_MRD   = 3'd2,
    ST_EXEC  = 3'd3,
    ST_HALT  = 3'd4
  } fth_state_e;

  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_INCIP = 3'd1,
    OP_LDA   = 3'd2,
    OP_JMPA  = 3'd3,
    OP_BAD   = 3'd4
  } fth_op_e;
endpackage

// File: rtl/fth_decode.sv
module fth_decode
  import fth_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] instr_i,
  output fth_op_e       op_o,
  output logic          mem_op_o
);
  logic upper_zero;

  generate
    if (DW > OPC_W) begin : g_wide
      assign upper_zero = ~|instr_i[DW-1:OPC_W];
    end else begin : g_exact
      assign upper_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    op_o = OP_BAD;
    if (upper_zero) begin
      case (instr_i[OPC_W-1:0])
        OPC_PUSH:  op_o = OP_PUSH;
        OPC_INCIP: op_o = OP_INCIP;
        OPC_LDA:   op_o = OP_LDA;
        OPC_JMPA:  op_o = OP_JMPA;
        default:   op_o = OP_BAD;
      endcase
    end
    mem_op_o = (op_o == OP_PUSH) || (op_o == OP_LDA);
  end
endmodule

// File: rtl/fth_seq.sv
module fth_seq
  import fth_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  fth_op_e    dec_op_i,
  input  logic       dec_mem_i,
  output fth_state_e state_o,
  output fth_op_e    op_o,
  output logic       illegal_o
);
  fth_state_e state_q;
  fth_op_e    op_q;
  logic       illegal_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_FETCH;
      op_q      <= OP_BAD;
      illegal_q <= 1'b0;
    end else begin
      case (state_q)
        ST_FETCH: state_q <= ST_DEC;
        ST_DEC: begin
          if (dec_op_i == OP_BAD) begin
            illegal_q <= 1'b1;
            state_q   <= ST_HALT;
          end else begin
            op_q    <= dec_op_i;
            state_q <= dec_mem_i ? ST_MRD : ST_EXEC;
          end
        end
        ST_MRD:  state_q <= ST_EXEC;
        ST_EXEC: state_q <= ST_FETCH;
        default: state_q <= ST_HALT;
      endcase
    end
  end

  assign state_o   = state_q;
  assign op_o      = op_q;
  assign illegal_o = illegal_q;

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_q |=> illegal_q && (state_q == ST_HALT));
endmodule

// File: rtl/fth_regs.sv
module fth_regs
  import fth_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int RST_PC = 'h08,
  parameter int RST_IP = 'h33,
  parameter int RST_A  = 'h32,
  parameter int RST_SP = 'h39
) (
  input  logic          clk,
  input  logic          rst,
  input  fth_state_e    state_i,
  input  fth_op_e       op_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] ip_o,
  output logic [AW-1:0] a_o,
  output logic [AW-1:0] sp_o,
  output logic          retire_o
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [AW-1:0] PC0 = AW'(RST_PC);
  localparam logic [AW-1:0] IP0 = AW'(RST_IP);
  localparam logic [AW-1:0] A0  = AW'(RST_A);
  localparam logic [AW-1:0] SP0 = AW'(RST_SP);

  logic [AW-1:0] pc_q, ip_q, a_q, sp_q;
  logic          retire_q;
  logic          exec;

  assign exec = (state_i == ST_EXEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= PC0;
      ip_q     <= IP0;
      a_q      <= A0;
      sp_q     <= SP0;
      retire_q <= 1'b0;
    end else begin
      retire_q <= exec;
      if (exec) begin
        case (op_i)
          OP_PUSH: begin
            sp_q <= sp_q + ONE;
            pc_q <= pc_q + ONE;
          end
          OP_INCIP: begin
            ip_q <= ip_q + ONE;
            pc_q <= pc_q + ONE;
          end
          OP_LDA: begin
            a_q  <= mem_rdata_i[AW-1:0];
            pc_q <= pc_q + ONE;
          end
          OP_JMPA: pc_q <= a_q + ONE;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (state_i)
      ST_MRD:  mem_addr_o = ip_q;
      ST_EXEC: mem_addr_o = sp_q;
      default: mem_addr_o = pc_q;
    endcase
    mem_we_o    = exec && (op_i == OP_PUSH);
    mem_wdata_o = mem_rdata_i;
  end

  assign pc_o     = pc_q;
  assign ip_o     = ip_q;
  assign a_o      = a_q;
  assign sp_o     = sp_q;
  assign retire_o = retire_q;

  // R2
  push_adv_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |=> (sp_q == $past(sp_q) + ONE));

  // R7
  still_chk: assert property (@(posedge clk) disable iff (rst)
    (!retire_q && !$past(rst)) |->
      ($stable(pc_q) && $stable(ip_q) && $stable(a_q) && $stable(sp_q)));

  // R5
  jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_q && (pc_q != $past(pc_q) + ONE)) |-> (pc_q == $past(a_q) + ONE));
endmodule

// File: rtl/fth_core.sv
module fth_core
  import fth_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int RST_PC = 'h08,
  parameter int RST_IP = 'h33,
  parameter int RST_A  = 'h32,
  parameter int RST_SP = 'h39
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] ip_o,
  output logic [AW-1:0] a_o,
  output logic [AW-1:0] sp_o,
  output logic          retire_o,
  output logic          illegal_o
);
  fth_op_e    dec_op;
  logic       dec_mem;
  fth_state_e state;
  fth_op_e    cur_op;

  fth_decode #(.DW(DW)) u_dec (
    .instr_i  (mem_rdata_i),
    .op_o     (dec_op),
    .mem_op_o (dec_mem)
  );

  fth_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .dec_op_i  (dec_op),
    .dec_mem_i (dec_mem),
    .state_o   (state),
    .op_o      (cur_op),
    .illegal_o (illegal_o)
  );

  fth_regs #(
    .AW(AW), .DW(DW),
    .RST_PC(RST_PC), .RST_IP(RST_IP), .RST_A(RST_A), .RST_SP(RST_SP)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .state_i     (state),
    .op_i        (cur_op),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .pc_o        (pc_o),
    .ip_o        (ip_o),
    .a_o         (a_o),
    .sp_o        (sp_o),
    .retire_o    (retire_o)
  );

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |=> (!retire_o && !mem_we_o && $stable(pc_o)));

  // R9
  we_then_retire_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |=> retire_o);
endmodule

// File: tb/fth_core_tb.sv
module fth_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        mem_we_o;
  logic [15:0] pc_o, ip_o, a_o, sp_o;
  logic        retire_o, illegal_o;

  int n_cmp = 0;
  int n_bad = 0;

  logic [15:0] mem [256];
  logic [15:0] mm  [256];

  logic [15:0] m_pc, m_ip, m_a, m_sp, m_op;
  logic        m_ret, m_ill, m_jmp, exp_we;
  int          m_phase, m_len;

  always #10 clk = ~clk;

  fth_core u_dut (
    .clk(clk), .rst(rst),
    .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i),
    .pc_o(pc_o), .ip_o(ip_o), .a_o(a_o), .sp_o(sp_o),
    .retire_o(retire_o), .illegal_o(illegal_o)
  );

  always @(posedge clk) begin
    if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
    mem_rdata_i <= mem[mem_addr_o[7:0]];
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle behavioural reference, sampled at the falling edge
  always @(negedge clk) begin
    if (rst) begin
      // R1 reset state
      chk("R1 pc", pc_o, 16'h0008);
      chk("R1 ip", ip_o, 16'h0033);
      chk("R1 a", a_o, 16'h0032);
      chk("R1 sp", sp_o, 16'h0039);
      chk("R1 flags", {13'd0, retire_o, illegal_o, mem_we_o}, 16'h0000);
      m_pc = 16'h0008; m_ip = 16'h0033; m_a = 16'h0032; m_sp = 16'h0039;
      m_phase = 1; m_len = 3; m_ret = 1'b0; m_ill = 1'b0; m_jmp = 1'b0; m_op = 16'h0;
    end else begin
      exp_we = !m_ill && (m_phase >= 2) && (m_phase == m_len - 1) && (m_op == 16'h9613);
      chk(m_jmp ? "R5 pc" : "R6 pc", pc_o, m_pc);
      chk("R3 ip", ip_o, m_ip);
      chk("R4 a", a_o, m_a);
      chk("R2 sp", sp_o, m_sp);
      chk("R7 retire", {15'd0, retire_o}, {15'd0, m_ret});
      chk("R8 illegal", {15'd0, illegal_o}, {15'd0, m_ill});
      chk("R9 we", {15'd0, mem_we_o}, {15'd0, exp_we});
      if (exp_we) begin
        chk("R9 waddr", mem_addr_o, m_sp);
        chk("R2 wdata", mem_wdata_o, mm[m_ip[7:0]]);
      end
      m_ret = 1'b0;
      if (!m_ill) begin
        if (m_phase == 0) begin
          m_phase = 1;
        end else if (m_phase == 1) begin
          m_op = mm[m_pc[7:0]];
          if (m_op == 16'h9613 || m_op == 16'h2043) begin
            m_len = 4; m_phase = 2;
          end else if (m_op == 16'h7003 || m_op == 16'h2004) begin
            m_len = 3; m_phase = 2;
          end else begin
            m_ill = 1'b1;
          end
        end else if (m_phase == m_len - 1) begin
          m_jmp = 1'b0;
          case (m_op)
            16'h9613: begin mm[m_sp[7:0]] = mm[m_ip[7:0]]; m_sp = m_sp + 16'd1; m_pc = m_pc + 16'd1; end
            16'h7003: begin m_ip = m_ip + 16'd1; m_pc = m_pc + 16'd1; end
            16'h2043: begin m_a = mm[m_ip[7:0]]; m_pc = m_pc + 16'd1; end
            default:  begin m_pc = m_a + 16'd1; m_jmp = 1'b1; end
          endcase
          m_ret = 1'b1;
          m_phase = 0;
        end else begin
          m_phase = m_phase + 1;
        end
      end
    end
  end

  task automatic put(input int addr, input logic [15:0] val);
    mem[addr] = val;
    mm[addr]  = val;
  endtask

  task automatic load_image(input int which);
    for (int i = 0; i < 256; i++) put(i, 16'h0000);
    for (int i = 'h39; i <= 'h3F; i++) put(i, 16'hFFFF);
    if (which == 1) begin
      put('h08, 16'h9613); put('h09, 16'h7003); put('h0A, 16'h2043);
      put('h0B, 16'h7003); put('h0C, 16'h2004);
      put('h2E, 16'h0028); put('h2F, 16'hB461); put('h30, 16'h8614);
      put('h32, 16'h0007); put('h33, 16'h0003); put('h34, 16'h002E); put('h35, 16'h0020);
    end else if (which == 2) begin
      put('h08, 16'h9613); put('h09, 16'h7003); put('h0A, 16'h9613);
      put('h0B, 16'h7003); put('h0C, 16'h9613); put('h0D, 16'h2043);
      put('h0E, 16'h2004);
      put('h33, 16'h1234); put('h34, 16'hBEEF); put('h35, 16'h0040);
      put('h36, 16'hFFFF); put('h37, 16'h5A5A);
      put('h41, 16'h7003); put('h42, 16'h2043); put('h43, 16'h2004);
      put('h00, 16'h7003); put('h01, 16'h9613);
    end else begin
      put('h08, 16'h9614);
    end
  endtask

  task automatic run_scn(input int which);
    @(negedge clk); #1 rst = 1'b1;
    @(negedge clk); #1 load_image(which);
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    repeat (80) @(negedge clk);
    #2;
  endtask

  initial begin
    // R10: literal thread followed by the inner interpreter
    run_scn(1);
    chk("R10 pc", pc_o, 16'h002F);
    chk("R10 ip", ip_o, 16'h0035);
    chk("R10 a", a_o, 16'h002E);
    chk("R10 sp", sp_o, 16'h003A);
    chk("R10 cell39", mem['h39], 16'h0003);
    chk("R10 cell3A", mem['h3A], 16'hFFFF);
    chk("R8 halted on 0xB461", {15'd0, illegal_o}, 16'h0001);

    // R8: near-miss opcode as the first word, then reset clears the fault
    run_scn(3);
    chk("R8 pc held", pc_o, 16'h0008);
    chk("R8 sp held", sp_o, 16'h0039);
    chk("R8 no write", mem['h39], 16'hFFFF);
    chk("R8 flag", {15'd0, illegal_o}, 16'h0001);

    // R2 R4 R5: back-to-back pushes, jump through 0xFFFF wraps to 0
    run_scn(2);
    chk("R5 wrap pc", pc_o, 16'h0002);
    chk("R3 ip", ip_o, 16'h0037);
    chk("R4 a", a_o, 16'hFFFF);
    chk("R2 sp", sp_o, 16'h003D);
    chk("R2 cell39", mem['h39], 16'h1234);
    chk("R2 cell3A", mem['h3A], 16'hBEEF);
    chk("R2 cell3B", mem['h3B], 16'h0040);
    chk("R2 cell3C", mem['h3C], 16'h5A5A);
    for (int i = 0; i < 256; i++) chk("R9 image", mem[i], mm[i]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule